// File: doc/BRIEF.md
# Background Memory CRC Checker

This block checks a region of memory for corruption while the rest of the chip goes about its work. Software programs a start address, a word count, an expected (golden) CRC and a watchdog window, then sets the enable bit. From then on the block reads the region one 32-bit word at a time. It only reads in cycles when the arbiter reports that no other master is using the memory. Each word is folded into a running CRC in the same cycle. At the end of every pass the result is compared with the golden value.

The block restarts on its own after each pass for as long as it stays enabled. It raises sticky flags for a CRC mismatch, for a read that came back marked with an ECC or parity error, and for a pass whose read phase outlived the watchdog window. Interrupt outputs can be enabled for these flags. Writing the commit bit freezes the configuration until reset. The flag-clear register stays writable after the commit.

Top module: `bgscan_crc_top`

## Requirements
- R1: `mem_rd` is high only in a cycle where `mem_idle` is high and a pass is in its read phase. When `mem_idle` is low, the engine issues no read and its pointer, remaining count and CRC do not change.
- R2: A pass reads exactly the programmed word count. The first read of a pass is at the start address, and each later read is at the previous address plus one. Read data and `mem_rerr` are taken in the same cycle as `mem_rd`.
- R3: The CRC is seeded with 0xFFFFFFFF at the start of every pass and uses polynomial 0x04C11DB7. Each word is processed from bit 31 down to bit 0, with no reflection and no final XOR. `crc_result` takes the final value at the end of the compare cycle and resets to 0.
- R4: If the final CRC differs from the golden value, `flag_crc_fail` is set. `irq_err` equals (`flag_crc_fail` OR `flag_timeout`) AND control bit 3.
- R5: `pass_done` is high for exactly one cycle, the compare cycle that follows the last read. With `mem_idle` held high, consecutive `pass_done` pulses are count+1 cycles apart.
- R6: While enable (control bit 0) stays set, a new pass starts in the cycle right after the compare cycle. The new pass reads from the start address with a fresh seed.
- R7: A read with `mem_rerr` high sets `flag_mem_err`. `irq_mem` equals `flag_mem_err` AND control bit 2.
- R8: Let W be the window register. A cycle counter starts at 0 with each pass and counts read-phase cycles, stalls included. If W is nonzero and the counter reaches W during the read phase, `flag_timeout` is set. A read phase of W or fewer cycles never sets it, and W = 0 turns the check off.
- R9: The register select `cfg_sel` chooses the target: 0 is the start address, 1 the word count, 2 the golden CRC, 3 the window and 4 the control register. Writing control with bit 1 set commits the configuration. After that, writes to selects 0 to 4 are ignored until reset.
- R10: Select 5 is a write-1-to-clear register: bit 0 clears `flag_crc_fail`, bit 1 clears `flag_mem_err` and bit 2 clears `flag_timeout`. It works before and after commit. A flag set in the same cycle as its clear stays set.
- R11: After reset all flags, interrupts, `pass_done`, `mem_rd` and `crc_result` are 0, and no pass runs until enable is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| mem_idle | input | 1 | Arbiter reports the memory is free this cycle |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW (16) | Word address of the read |
| mem_rdata | input | DW (32) | Read data, valid in the cycle of `mem_rd` |
| mem_rerr | input | 1 | ECC or parity error on this read |
| pass_done | output | 1 | Compare-cycle strobe |
| crc_result | output | DW (32) | CRC of the last completed pass |
| flag_crc_fail | output | 1 | Sticky CRC mismatch flag |
| flag_mem_err | output | 1 | Sticky memory read error flag |
| flag_timeout | output | 1 | Sticky watchdog flag |
| irq_err | output | 1 | Mismatch or timeout interrupt |
| irq_mem | output | 1 | Memory error interrupt |

## Verification
The hardest case to reach from the ports is a pass that is starved of idle cycles long enough to trip the watchdog. The bench reaches it by holding `mem_idle` low across a read phase while a short window is programmed. It then runs the same window with no contention to show that the flag stays clear. Long runs with a pseudo-random idle pattern mix stalls into back-to-back passes. A behavioural model predicts every read, address, CRC and flag in every cycle.

// File: rtl/bgscan_crc_pkg.sv
package bgscan_crc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CMP} scan_st_t;

   localparam logic [2:0] SEL_BASE   = 3'd0;
   localparam logic [2:0] SEL_COUNT  = 3'd1;
   localparam logic [2:0] SEL_GOLDEN = 3'd2;
   localparam logic [2:0] SEL_WINDOW = 3'd3;
   localparam logic [2:0] SEL_CTRL   = 3'd4;
   localparam logic [2:0] SEL_CLEAR  = 3'd5;

   localparam int CTL_ENABLE = 0;
   localparam int CTL_COMMIT = 1;
   localparam int CTL_MEM_IE = 2;
   localparam int CTL_ERR_IE = 3;
endpackage

// File: rtl/bgscan_crc_fold.sv
module bgscan_crc_fold #(
   parameter int          DW   = 32,
   parameter logic [DW-1:0] POLY = 32'h04C11DB7
) (
   input  logic [DW-1:0] crc_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] crc_o
);
   logic [DW-1:0] chain [0:DW];
   assign chain[0] = crc_i;

   // one shift-and-reduce stage per data bit, MSB first
   for (genvar i = 0; i < DW; i++) begin : g_stage
      logic fb;
      assign fb = chain[i][DW-1] ^ data_i[DW-1-i];
      assign chain[i+1] = {chain[i][DW-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_o = chain[DW];
endmodule

// File: rtl/bgscan_crc_cfg.sv
module bgscan_crc_cfg
   import bgscan_crc_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int WW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [2:0]    sel,
   input  logic [31:0]   wdata,
   output logic [AW-1:0] base_o,
   output logic [CW-1:0] count_o,
   output logic [DW-1:0] golden_o,
   output logic [WW-1:0] window_o,
   output logic          enable_o,
   output logic          mem_ie_o,
   output logic          err_ie_o,
   output logic          locked_o,
   output logic [2:0]    clear_o
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   assign clear_o = (we && sel == SEL_CLEAR) ? wdata[2:0] : 3'b000;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_o   <= '0;
         count_o  <= '0;
         golden_o <= '0;
         window_o <= '0;
         enable_o <= 1'b0;
         mem_ie_o <= 1'b0;
         err_ie_o <= 1'b0;
         locked_o <= 1'b0;
      end else if (we && !locked_o) begin
         case (sel)
            SEL_BASE:   base_o   <= wdata[AW-1:0];
            SEL_COUNT:  count_o  <= wdata[CW-1:0];
            SEL_GOLDEN: golden_o <= wdata[DW-1:0];
            SEL_WINDOW: window_o <= wdata[WW-1:0];
            SEL_CTRL: begin
               enable_o <= wdata[CTL_ENABLE];
               locked_o <= wdata[CTL_COMMIT];
               mem_ie_o <= wdata[CTL_MEM_IE];
               err_ie_o <= wdata[CTL_ERR_IE];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bgscan_crc_scan.sv
module bgscan_crc_scan
   import bgscan_crc_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int WW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   input  logic [WW-1:0] window,
   input  logic          mem_idle,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          pass_start,
   output logic          pass_done,
   output logic          wd_hit
);
   scan_st_t      st;
   logic [AW-1:0] ptr;
   logic [CW-1:0] remain;
   logic [WW-1:0] wd_cnt;

   assign mem_rd     = (st == ST_READ) && mem_idle && (remain != '0);
   assign mem_addr   = ptr;
   assign pass_done  = (st == ST_CMP);
   assign pass_start = enable && (st == ST_IDLE || st == ST_CMP);
   assign wd_hit     = (st == ST_READ) && (window != '0) && (wd_cnt == window);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ptr    <= '0;
         remain <= '0;
         wd_cnt <= '0;
      end else if (pass_start) begin
         st     <= ST_READ;
         ptr    <= base;
         remain <= count;
         wd_cnt <= '0;
      end else begin
         case (st)
            ST_READ: begin
               if (wd_cnt != {WW{1'b1}}) wd_cnt <= wd_cnt + 1'b1;
               if (remain == '0) begin
                  st <= ST_CMP;
               end else if (mem_rd) begin
                  ptr    <= ptr + 1'b1;
                  remain <= remain - 1'b1;
                  if (remain == CW'(1)) st <= ST_CMP;
               end
            end
            ST_CMP:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bgscan_crc_top.sv
module bgscan_crc_top
   import bgscan_crc_pkg::*;
#(
   parameter int          AW   = 16,
   parameter int          CW   = 16,
   parameter int          WW   = 16,
   parameter int          DW   = 32,
   parameter logic [DW-1:0] POLY = 32'h04C11DB7,
   parameter logic [DW-1:0] SEED = 32'hFFFFFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   input  logic          mem_idle,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rerr,
   output logic          pass_done,
   output logic [DW-1:0] crc_result,
   output logic          flag_crc_fail,
   output logic          flag_mem_err,
   output logic          flag_timeout,
   output logic          irq_err,
   output logic          irq_mem
);
   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("bgscan_crc_top: DW must be within 8..32");
   end
   if (AW < 1 || AW > 32 || CW < 1 || CW > 32 || WW < 1 || WW > 32) begin : g_bad_w
      $error("bgscan_crc_top: AW, CW and WW must be within 1..32");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("bgscan_crc_top: polynomial needs its constant term");
   end

   logic [AW-1:0] cfg_base;
   logic [CW-1:0] cfg_count;
   logic [DW-1:0] cfg_golden;
   logic [WW-1:0] cfg_window;
   logic          cfg_enable, cfg_mem_ie, cfg_err_ie, cfg_locked;
   logic [2:0]    clr_bits;
   logic          pass_start, wd_hit;
   logic [DW-1:0] crc_q, fold_out;

   bgscan_crc_cfg #(.AW(AW), .CW(CW), .WW(WW), .DW(DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .base_o(cfg_base), .count_o(cfg_count), .golden_o(cfg_golden),
      .window_o(cfg_window), .enable_o(cfg_enable), .mem_ie_o(cfg_mem_ie),
      .err_ie_o(cfg_err_ie), .locked_o(cfg_locked), .clear_o(clr_bits)
   );

   bgscan_crc_scan #(.AW(AW), .CW(CW), .WW(WW)) u_scan (
      .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .base(cfg_base),
      .count(cfg_count), .window(cfg_window), .mem_idle(mem_idle),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .pass_start(pass_start),
      .pass_done(pass_done), .wd_hit(wd_hit)
   );

   bgscan_crc_fold #(.DW(DW), .POLY(POLY)) u_fold (
      .crc_i(crc_q), .data_i(mem_rdata), .crc_o(fold_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q      <= SEED;
         crc_result <= '0;
      end else begin
         if (pass_done) crc_result <= crc_q;
         if (pass_start)  crc_q <= SEED;
         else if (mem_rd) crc_q <= fold_out;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_crc_fail <= 1'b0;
         flag_mem_err  <= 1'b0;
         flag_timeout  <= 1'b0;
      end else begin
         flag_crc_fail <= (flag_crc_fail & ~clr_bits[0]) | (pass_done && crc_q != cfg_golden);
         flag_mem_err  <= (flag_mem_err  & ~clr_bits[1]) | (mem_rd && mem_rerr);
         flag_timeout  <= (flag_timeout  & ~clr_bits[2]) | wd_hit;
      end
   end

   assign irq_err = (flag_crc_fail | flag_timeout) & cfg_err_ie;
   assign irq_mem = flag_mem_err & cfg_mem_ie;
endmodule

// File: rtl/bgscan_crc_chk.sv
module bgscan_crc_chk #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int WW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_idle,
   input logic          mem_rd,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rerr,
   input logic          pass_done,
   input logic          flag_crc_fail,
   input logic          flag_mem_err,
   input logic          irq_mem,
   input logic [DW-1:0] crc_q,
   input logic [DW-1:0] cfg_golden,
   input logic [AW-1:0] cfg_base,
   input logic [CW-1:0] cfg_count,
   input logic [WW-1:0] cfg_window,
   input logic          cfg_locked
);
   a_r1_read_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mem_idle);

   a_r2_address_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

   a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   a_r4_mismatch_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_done && crc_q != cfg_golden) |=> flag_crc_fail);

   a_r7_read_error_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_rerr) |=> flag_mem_err);

   a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mem |-> flag_mem_err);

   a_r9_commit_freezes_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_locked |=> ($stable(cfg_base) && $stable(cfg_count)
                      && $stable(cfg_golden) && $stable(cfg_window)));
endmodule

bind bgscan_crc_top bgscan_crc_chk #(.AW(AW), .CW(CW), .WW(WW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_idle(mem_idle), .mem_rd(mem_rd),
   .mem_addr(mem_addr), .mem_rerr(mem_rerr), .pass_done(pass_done),
   .flag_crc_fail(flag_crc_fail), .flag_mem_err(flag_mem_err), .irq_mem(irq_mem),
   .crc_q(crc_q), .cfg_golden(cfg_golden), .cfg_base(cfg_base),
   .cfg_count(cfg_count), .cfg_window(cfg_window), .cfg_locked(cfg_locked)
);

// File: tb/bgscan_crc_tb.sv
`timescale 1ns/1ps
module bgscan_crc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_idle = 1'b1;
   logic        mem_rd, mem_rerr, pass_done;
   logic [15:0] mem_addr;
   logic [31:0] mem_rdata, crc_result;
   logic        flag_crc_fail, flag_mem_err, flag_timeout, irq_err, irq_mem;

   always #4 clk = ~clk;

   bgscan_crc_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .mem_idle(mem_idle), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
      .pass_done(pass_done), .crc_result(crc_result),
      .flag_crc_fail(flag_crc_fail), .flag_mem_err(flag_mem_err),
      .flag_timeout(flag_timeout), .irq_err(irq_err), .irq_mem(irq_mem)
   );

   // bench memory
   logic [31:0] bmem [64];
   logic        rerr_on = 1'b0;
   logic [15:0] rerr_at = '0;
   assign mem_rdata = bmem[mem_addr[5:0]];
   assign mem_rerr  = rerr_on && (mem_addr == rerr_at);

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] r = c;
      for (int i = 31; i >= 0; i--)
         r = (r[31] ^ d[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
      return r;
   endfunction

   function automatic logic [31:0] golden_of(input int b, input int n);
      logic [31:0] r = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) r = ref_fold(r, bmem[b + i]);
      return r;
   endfunction

   // ---------------- behavioural reference model ----------------
   int          m_st = 0;            // 0 idle, 1 reading, 2 compare
   logic [15:0] m_base = '0, m_cnt = '0, m_win = '0, m_ptr = '0;
   logic [31:0] m_gold = '0, m_crc = 32'hFFFFFFFF, m_res = '0;
   bit          m_en = 0, m_lock = 0, m_mie = 0, m_eie = 0;
   bit          m_ff = 0, m_fm = 0, m_ft = 0;
   int          m_rem = 0, m_wd = 0;
   bit          s_ff, s_fm, s_ft, m_rd;
   logic [2:0]  m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_base = '0; m_cnt = '0; m_win = '0; m_ptr = '0;
         m_gold = '0; m_crc = 32'hFFFFFFFF; m_res = '0;
         m_en = 0; m_lock = 0; m_mie = 0; m_eie = 0;
         m_ff = 0; m_fm = 0; m_ft = 0; m_rem = 0; m_wd = 0;
      end else begin
         s_ff = 0; s_fm = 0; s_ft = 0;
         m_rd = (m_st == 1) && mem_idle && (m_rem != 0);
         case (m_st)
            0: if (m_en) begin
                  m_st = 1; m_ptr = m_base; m_rem = m_cnt; m_crc = 32'hFFFFFFFF; m_wd = 0;
               end
            1: begin
                  if (m_win != 0 && m_wd == m_win) s_ft = 1;
                  m_wd++;
                  if (m_rem == 0) m_st = 2;
                  else if (m_rd) begin
                     m_crc = ref_fold(m_crc, bmem[m_ptr[5:0]]);
                     if (rerr_on && m_ptr == rerr_at) s_fm = 1;
                     m_ptr++; m_rem--;
                     if (m_rem == 0) m_st = 2;
                  end
               end
            default: begin
                  m_res = m_crc;
                  if (m_crc != m_gold) s_ff = 1;
                  if (m_en) begin
                     m_st = 1; m_ptr = m_base; m_rem = m_cnt; m_crc = 32'hFFFFFFFF; m_wd = 0;
                  end else m_st = 0;
               end
         endcase
         m_clr = (cfg_we && cfg_sel == 3'd5) ? cfg_wdata[2:0] : 3'b000;
         if (cfg_we && !m_lock) begin
            case (cfg_sel)
               3'd0: m_base = cfg_wdata[15:0];
               3'd1: m_cnt  = cfg_wdata[15:0];
               3'd2: m_gold = cfg_wdata;
               3'd3: m_win  = cfg_wdata[15:0];
               3'd4: begin
                  m_en = cfg_wdata[0]; m_lock = cfg_wdata[1];
                  m_mie = cfg_wdata[2]; m_eie = cfg_wdata[3];
               end
               default: ;
            endcase
         end
         m_ff = (m_ff & !m_clr[0]) | s_ff;
         m_fm = (m_fm & !m_clr[1]) | s_fm;
         m_ft = (m_ft & !m_clr[2]) | s_ft;
      end
   end

   // per-cycle comparison, after inputs for the cycle are driven
   bit exp_rd;
   always @(negedge clk) begin
      #1;
      exp_rd = (m_st == 1) && mem_idle && (m_rem != 0);
      chk("R1 mem_rd", {31'd0, mem_rd}, {31'd0, exp_rd});
      if (exp_rd) chk("R2 mem_addr", {16'd0, mem_addr}, {16'd0, m_ptr});
      chk("R5 pass_done", {31'd0, pass_done}, {31'd0, m_st == 2});
      chk("R3 crc_result", crc_result, m_res);
      chk("R4 flag_crc_fail", {31'd0, flag_crc_fail}, {31'd0, m_ff});
      chk("R7 flag_mem_err", {31'd0, flag_mem_err}, {31'd0, m_fm});
      chk("R8 flag_timeout", {31'd0, flag_timeout}, {31'd0, m_ft});
      chk("R4 irq_err", {31'd0, irq_err}, {31'd0, (m_ff | m_ft) & m_eie});
      chk("R7 irq_mem", {31'd0, irq_mem}, {31'd0, m_fm & m_mie});
   end

   // pseudo-random arbiter contention
   bit          stall_rand = 0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stall_rand) mem_idle <= lfsr[0] | lfsr[3];
   end

   int done_seen = 0;
   always @(negedge clk) begin
      #3;
      if (pass_done) done_seen++;
   end

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      do begin @(negedge clk); #2; n++; end while (!pass_done && n < 2000);
   endtask

   task automatic stop_and_clear();
      wr(3'd4, 32'd0);
      repeat (30) @(negedge clk);
      wr(3'd5, 32'd7);
   endtask

   int gap;
   logic [31:0] g;

   initial begin
      for (int i = 0; i < 64; i++) bmem[i] = (i * 32'h9E3779B9) ^ (32'h5A5A0000 + i);
      fork
         begin
            repeat (3) @(negedge clk);
            #2;
            chk("R11 reset mem_rd", {31'd0, mem_rd}, 32'd0);
            chk("R11 reset flags", {29'd0, flag_crc_fail, flag_mem_err, flag_timeout}, 32'd0);
            chk("R11 reset crc_result", crc_result, 32'd0);
            @(negedge clk); rst_n = 1'b1;
            repeat (5) @(negedge clk);
            #2 chk("R11 no pass before enable", {31'd0, pass_done | mem_rd}, 32'd0);

            // main pass, no contention
            g = golden_of(4, 8);
            wr(3'd0, 32'd4); wr(3'd1, 32'd8); wr(3'd2, g); wr(3'd3, 32'd0);
            wr(3'd4, 32'd13);
            wait_done();
            gap = 0;
            do begin @(negedge clk); #2; gap++; end while (!pass_done && gap < 100);
            chk("R5 pass length count+1", gap, 32'd9);
            @(negedge clk); #2;
            chk("R3 crc_result equals golden", crc_result, g);
            chk("R6 restart at base", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'd4});
            chk("R4 no fail on match", {31'd0, flag_crc_fail}, 32'd0);

            // random contention, continuous passes
            done_seen = 0;
            stall_rand = 1;
            repeat (300) @(negedge clk);
            stall_rand = 0; mem_idle = 1'b1;
            chk("R6 several passes", {31'd0, done_seen >= 3}, 32'd1);
            chk("R8 window zero disables", {31'd0, flag_timeout}, 32'd0);

            // golden mismatch
            stop_and_clear();
            wr(3'd2, g ^ 32'h1);
            wr(3'd4, 32'd13);
            wait_done();
            @(negedge clk); #2;
            chk("R4 mismatch flag", {31'd0, flag_crc_fail}, 32'd1);
            chk("R4 irq_err", {31'd0, irq_err}, 32'd1);
            stop_and_clear();
            @(negedge clk); #2;
            chk("R10 clear flags", {29'd0, flag_crc_fail, flag_mem_err, flag_timeout}, 32'd0);

            // read error pass-through
            wr(3'd2, g);
            rerr_on = 1'b1; rerr_at = 16'd6;
            wr(3'd4, 32'd13);
            wait_done();
            rerr_on = 1'b0;
            chk("R7 mem error flag", {31'd0, flag_mem_err}, 32'd1);
            chk("R7 irq_mem enabled", {31'd0, irq_mem}, 32'd1);
            wr(3'd4, 32'd1);
            @(negedge clk); #2;
            chk("R7 irq_mem masked", {31'd0, irq_mem}, 32'd0);

            // watchdog: starved pass
            stop_and_clear();
            wr(3'd3, 32'd10);
            mem_idle = 1'b0;
            wr(3'd4, 32'd1);
            repeat (20) @(negedge clk);
            #2 chk("R8 timeout under starvation", {31'd0, flag_timeout}, 32'd1);
            mem_idle = 1'b1;
            stop_and_clear();
            wr(3'd4, 32'd1);
            repeat (40) @(negedge clk);
            #2 chk("R8 no timeout within window", {31'd0, flag_timeout}, 32'd0);

            // commit, then attempts to change configuration
            stop_and_clear();
            wr(3'd4, 32'd11);
            wr(3'd0, 32'd20);
            wr(3'd4, 32'd0);
            wait_done();
            @(negedge clk); #2;
            chk("R9 base kept after commit", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'd4});
            rerr_on = 1'b1; rerr_at = 16'd5;
            wait_done();
            rerr_on = 1'b0;
            chk("R9 still enabled, R7 flag", {31'd0, flag_mem_err}, 32'd1);
            wr(3'd5, 32'd2);
            @(negedge clk); #2;
            chk("R10 clear after commit", {31'd0, flag_mem_err}, 32'd0);
            repeat (20) @(negedge clk);
         end
         begin
            repeat (50000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog expired, actual=hung expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule